// File: doc/BRIEF.md
# Ethernet Transmit Sequencer with Padding and Collision Handling

This block drives the transmission of one frame that the host has already placed, or is still placing, in a local byte buffer. A one-cycle command carries the frame length, a start-point selector, a pad-disable flag and an FCS-inhibit flag. The block waits until enough bytes are in the buffer, then streams one byte per cycle to a serializer. Frames shorter than the Ethernet minimum are extended with zero bytes unless padding is disabled. On the last byte it tells an external CRC unit whether to append the FCS.

While a frame is on the wire, a collision indication is classified by how many bytes have gone out. A collision inside the 64-byte slot window leads to a jam, a random backoff and a retry from byte zero. A collision after that window leads to a jam and the frame is dropped. Sixteen collisions on one frame end the attempts. If the buffer runs dry before the frame ends, the frame is aborted. Each command ends with at most one registered event pulse.

Top module: `txpad_top`

## Requirements
- R1: After a command, the first byte goes out only once the buffer level reaches the selected start point: selector 0 = 5 bytes, 1 = 381 bytes, 2 = 1021 bytes, 3 = the whole frame. A start point larger than the frame length is lowered to the frame length.
- R2: With pad disable clear and a length below 60, exactly 60 bytes are sent: the buffer bytes followed by zero bytes. With pad disable set, exactly the given length is sent. Byte k is read from buffer address k, and `bufRdAddr` equals k while byte k is valid.
- R3: `fcsReq` is high together with `txLast` on the final byte when FCS inhibit is clear. It is never high when FCS inhibit is set.
- R4: A command with a length below 3 sends no byte, raises no event, and leaves the block ready for the next command.
- R5: A collision while byte index k < 64 is on the wire gives exactly 4 cycles of `jamActive`, followed by a backoff and a new attempt that starts again at address 0.
- R6: A collision while byte index k >= 64 is on the wire gives a 4-cycle jam, no further attempt, and one `evLate` pulse.
- R7: On the 16th collision of a frame, after its jam, no further attempt is made and `evExcess` pulses; `irq` pulses with it only when `excessIrqEn` is high.
- R8: If the byte due next lies beyond the current buffer level while still inside the frame length, the frame stops and `evUnderrun` pulses.
- R9: A frame that completes pulses `evTxOk` for one cycle, one cycle after its last byte. Over any command, at most one of `evTxOk`, `evLate`, `evExcess` and `evUnderrun` is raised, and never two in the same cycle.
- R10: After the jam of the n-th collision, the idle gap before the retry is at most (2^min(n,10) - 1) * SLOT_CYCLES + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle command strobe. It is taken only while the block is idle |
| cmdStartSel | input | 2 | Start point selector (see R1) |
| cmdPadDis | input | 1 | Disables padding to 60 bytes |
| cmdCrcInhibit | input | 1 | Suppresses the FCS request |
| cmdLen | input | 11 | Frame length in bytes, not counting the FCS |
| bufLevel | input | 11 | Number of frame bytes currently held in the buffer |
| bufRdAddr | output | 11 | Buffer read address, equal to the current byte index |
| bufRdData | input | 8 | Buffer data at `bufRdAddr`, read in the same cycle |
| colIn | input | 1 | Collision indication from the line |
| excessIrqEn | input | 1 | Enables `irq` on excessive collisions |
| txValid | output | 1 | A byte is presented to the serializer |
| txData | output | 8 | Byte to the serializer (zero for pad bytes) |
| txLast | output | 1 | Marks the final byte of the frame |
| fcsReq | output | 1 | Asks the CRC unit to append the FCS after this byte |
| jamActive | output | 1 | The jam pattern is being sent |
| evTxOk | output | 1 | Frame completed |
| evLate | output | 1 | Out-of-window collision; frame dropped |
| evExcess | output | 1 | Sixteen collisions; frame dropped |
| evUnderrun | output | 1 | Buffer ran dry before the end of the frame |
| irq | output | 1 | Interrupt for excessive collisions |

## Verification
The bench builds the block with SLOT_CYCLES set to 2 instead of 64. With this value, sixteen retries with backoff exponents up to the cap of 10 fit in a short run, so the excessive-collision path and the backoff bound at large exponents can be reached. The slot window (64), the jam length (4) and the start points stay at their defaults. This keeps the collision boundary at bytes 63 and 64 and the 381-byte start point with its underrun exactly as in use.

// File: rtl/txpad_pkg.sv
package txpad_pkg;
  localparam int START_TH0 = 5;
  localparam int START_TH1 = 381;
  localparam int START_TH2 = 1021;
  localparam int MIN_FRAME = 60;
  localparam int MIN_SEND  = 3;

  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_SEND, ST_JAM, ST_BACKOFF} txState_e;
  typedef enum logic [1:0] {JK_RETRY, JK_LATE, JK_EXCESS} jamKind_e;

  typedef struct packed {
    logic latchCmd;
    logic clrIdx;
    logic incIdx;
    logic loadJam;
    logic decJam;
    logic loadBo;
    logic decBo;
    logic incCol;
  } strobe_t;

  typedef struct packed {
    logic lenShort;
    logic startOk;
    logic idxLast;
    logic dataMissing;
    logic inWindow;
    logic jamDone;
    logic boDone;
    logic colFinal;
    logic crcInh;
  } status_t;
endpackage

// File: rtl/txpad_dp.sv
module txpad_dp
  import txpad_pkg::*;
#(
  parameter int LEN_W        = 11,
  parameter int WINDOW_BYTES = 64,
  parameter int JAM_CYCLES   = 4,
  parameter int SLOT_CYCLES  = 64,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [1:0]       cmdStartSel,
  input  logic             cmdPadDis,
  input  logic             cmdCrcInhibit,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [LEN_W-1:0] bufLevel,
  input  logic [7:0]       bufRdData,
  output logic [LEN_W-1:0] bufRdAddr,
  output logic [7:0]       txData,
  output status_t          sts
);
  localparam int COL_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int JAM_W = $clog2(JAM_CYCLES + 1);
  localparam int BO_W  = BACKOFF_CAP + $clog2(SLOT_CYCLES + 1) + 1;
  localparam int EXP_W = $clog2(BACKOFF_CAP + 1);

  logic [LEN_W-1:0] lenQ, idx, frameLen, need;
  logic [1:0]       selQ;
  logic             padDisQ, crcInhQ;
  logic [JAM_W-1:0] jamCnt;
  logic [BO_W-1:0]  boCnt;
  logic [COL_W-1:0] colCnt;
  logic [15:0]      lfsr;
  logic [EXP_W-1:0] expo;
  logic [BACKOFF_CAP-1:0] mask, slots;

  always_comb begin
    frameLen = (!padDisQ && lenQ < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : lenQ;
    case (selQ)
      2'd0:    need = LEN_W'(START_TH0);
      2'd1:    need = LEN_W'(START_TH1);
      2'd2:    need = LEN_W'(START_TH2);
      default: need = lenQ;
    endcase
    if (need > lenQ) need = lenQ;
    expo  = (colCnt > COL_W'(BACKOFF_CAP)) ? EXP_W'(BACKOFF_CAP) : EXP_W'(colCnt);
    mask  = (BACKOFF_CAP'(1) << expo) - BACKOFF_CAP'(1);
    slots = lfsr[BACKOFF_CAP-1:0] & mask;
  end

  assign sts.lenShort    = lenQ < LEN_W'(MIN_SEND);
  assign sts.startOk     = bufLevel >= need;
  assign sts.idxLast     = idx == frameLen - LEN_W'(1);
  assign sts.dataMissing = (idx < lenQ) && (idx >= bufLevel);
  assign sts.inWindow    = idx < LEN_W'(WINDOW_BYTES);
  assign sts.jamDone     = jamCnt == '0;
  assign sts.boDone      = boCnt == '0;
  assign sts.colFinal    = colCnt == COL_W'(MAX_ATTEMPTS - 1);
  assign sts.crcInh      = crcInhQ;
  assign bufRdAddr       = idx;
  assign txData          = (idx < lenQ) ? bufRdData : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0; selQ <= '0; padDisQ <= 1'b0; crcInhQ <= 1'b0;
      idx <= '0; jamCnt <= '0; boCnt <= '0; colCnt <= '0;
      lfsr <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (stb.latchCmd) begin
        lenQ <= cmdLen; selQ <= cmdStartSel;
        padDisQ <= cmdPadDis; crcInhQ <= cmdCrcInhibit;
        colCnt <= '0;
      end else if (stb.incCol) begin
        colCnt <= colCnt + COL_W'(1);
      end
      if (stb.latchCmd || stb.clrIdx) idx <= '0;
      else if (stb.incIdx)            idx <= idx + LEN_W'(1);
      if (stb.loadJam)     jamCnt <= JAM_W'(JAM_CYCLES - 1);
      else if (stb.decJam) jamCnt <= jamCnt - JAM_W'(1);
      if (stb.loadBo)     boCnt <= BO_W'(slots) * BO_W'(SLOT_CYCLES);
      else if (stb.decBo) boCnt <= boCnt - BO_W'(1);
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idx <= frameLen) else $error("index past frame end"); // R2
  AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    colCnt <= COL_W'(MAX_ATTEMPTS)) else $error("collision count overrun"); // R7
endmodule

// File: rtl/txpad_ctrl.sv
module txpad_ctrl
  import txpad_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    colIn,
  input  status_t sts,
  output strobe_t stb,
  output logic    txValid,
  output logic    txLast,
  output logic    fcsReq,
  output logic    jamActive,
  output logic    evTxOk,
  output logic    evLate,
  output logic    evExcess,
  output logic    evUnderrun
);
  txState_e  state, stateNx;
  jamKind_e  kind, kindNx;
  logic      okSet, lateSet, excSet, unSet;

  always_comb begin
    stb = '0;
    stateNx = state; kindNx = kind;
    txValid = 1'b0; txLast = 1'b0; fcsReq = 1'b0; jamActive = 1'b0;
    okSet = 1'b0; lateSet = 1'b0; excSet = 1'b0; unSet = 1'b0;
    case (state)
      ST_IDLE: if (cmdValid) begin
        stb.latchCmd = 1'b1;
        stateNx = ST_WAIT;
      end
      ST_WAIT: begin
        if (sts.lenShort)     stateNx = ST_IDLE;
        else if (sts.startOk) stateNx = ST_SEND;
      end
      ST_SEND: begin
        if (sts.dataMissing) begin
          unSet = 1'b1;
          stateNx = ST_IDLE;
        end else if (colIn) begin
          stb.clrIdx = 1'b1;
          stb.loadJam = 1'b1;
          stateNx = ST_JAM;
          if (sts.inWindow) begin
            stb.incCol = 1'b1;
            kindNx = sts.colFinal ? JK_EXCESS : JK_RETRY;
          end else begin
            kindNx = JK_LATE;
          end
        end else begin
          txValid = 1'b1;
          stb.incIdx = 1'b1;
          if (sts.idxLast) begin
            txLast = 1'b1;
            fcsReq = !sts.crcInh;
            okSet = 1'b1;
            stateNx = ST_IDLE;
          end
        end
      end
      ST_JAM: begin
        jamActive = 1'b1;
        if (!sts.jamDone) stb.decJam = 1'b1;
        else begin
          case (kind)
            JK_RETRY: begin stb.loadBo = 1'b1; stateNx = ST_BACKOFF; end
            JK_LATE:  begin lateSet = 1'b1; stateNx = ST_IDLE; end
            default:  begin excSet = 1'b1; stateNx = ST_IDLE; end
          endcase
        end
      end
      ST_BACKOFF: begin
        if (sts.boDone) stateNx = ST_SEND;
        else            stb.decBo = 1'b1;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; kind <= JK_RETRY;
      evTxOk <= 1'b0; evLate <= 1'b0; evExcess <= 1'b0; evUnderrun <= 1'b0;
    end else begin
      state <= stateNx; kind <= kindNx;
      evTxOk <= okSet; evLate <= lateSet; evExcess <= excSet; evUnderrun <= unSet;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evTxOk, evLate, evExcess, evUnderrun})) else $error("two events"); // R9
  AST_JAM_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(jamActive) |-> $past(colIn)) else $error("jam without collision"); // R5
  AST_FCS_THEN_OK: assert property (@(posedge clk) disable iff (!rstN)
    fcsReq |=> evTxOk) else $error("fcs request not at frame end"); // R3
  AST_LATE_AFTER_JAM: assert property (@(posedge clk) disable iff (!rstN)
    evLate |-> $past(jamActive)) else $error("late event without jam"); // R6
endmodule

// File: rtl/txpad_top.sv
module txpad_top
  import txpad_pkg::*;
#(
  parameter int LEN_W        = 11,
  parameter int WINDOW_BYTES = 64,
  parameter int JAM_CYCLES   = 4,
  parameter int SLOT_CYCLES  = 64,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdStartSel,
  input  logic             cmdPadDis,
  input  logic             cmdCrcInhibit,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [LEN_W-1:0] bufLevel,
  output logic [LEN_W-1:0] bufRdAddr,
  input  logic [7:0]       bufRdData,
  input  logic             colIn,
  input  logic             excessIrqEn,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast,
  output logic             fcsReq,
  output logic             jamActive,
  output logic             evTxOk,
  output logic             evLate,
  output logic             evExcess,
  output logic             evUnderrun,
  output logic             irq
);
  strobe_t stb;
  status_t sts;

  txpad_ctrl u_ctrl (
    .clk, .rstN, .cmdValid, .colIn, .sts, .stb,
    .txValid, .txLast, .fcsReq, .jamActive,
    .evTxOk, .evLate, .evExcess, .evUnderrun
  );

  txpad_dp #(
    .LEN_W(LEN_W), .WINDOW_BYTES(WINDOW_BYTES), .JAM_CYCLES(JAM_CYCLES),
    .SLOT_CYCLES(SLOT_CYCLES), .MAX_ATTEMPTS(MAX_ATTEMPTS), .BACKOFF_CAP(BACKOFF_CAP)
  ) u_dp (
    .clk, .rstN, .stb, .cmdStartSel, .cmdPadDis, .cmdCrcInhibit, .cmdLen,
    .bufLevel, .bufRdData, .bufRdAddr, .txData, .sts
  );

  assign irq = evExcess & excessIrqEn;
endmodule

// File: tb/sim_txpad_top.sv
module sim_txpad_top;
  localparam int SLOT = 2;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdPadDis = 1'b0, cmdCrcInhibit = 1'b0;
  logic [1:0] cmdStartSel = 2'd0;
  logic [10:0] cmdLen = '0, bufLevel = '0, bufRdAddr;
  logic [7:0] bufRdData, txData;
  logic colIn = 1'b0, excessIrqEn = 1'b0;
  logic txValid, txLast, fcsReq, jamActive, evTxOk, evLate, evExcess, evUnderrun, irq;

  int nChecks = 0, nFails = 0, cycles = 0;
  int bytes, padErr, attempts, jamCyc, nOk, nLate, nExc, nUn, nIrq, nFcs, lastAddr, gapErr;
  int colAt, colMax, injected, gap;
  bit inGap, prevJam;

  always #2.5 clk = ~clk;
  assign bufRdData = bufRdAddr[7:0] ^ 8'h5A;

  txpad_top #(.SLOT_CYCLES(SLOT)) u0 (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearStats();
    bytes = 0; padErr = 0; attempts = 0; jamCyc = 0; nOk = 0; nLate = 0; nExc = 0;
    nUn = 0; nIrq = 0; nFcs = 0; lastAddr = -1; gapErr = 0; injected = 0;
    inGap = 0; prevJam = 0; gap = 0;
  endtask

  task automatic issue(input logic [1:0] sel, input bit pd, input bit ci, input int len);
    clearStats();
    @(negedge clk);
    cmdStartSel = sel; cmdPadDis = pd; cmdCrcInhibit = ci; cmdLen = 11'(len); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      colIn = 1'b0;
      if (txValid) begin
        bytes++;
        if (bufRdAddr == 0) attempts++;
        if (bufRdAddr < cmdLen ? (txData != (bufRdAddr[7:0] ^ 8'h5A)) : (txData != 8'h00)) padErr++;
        if (txLast) lastAddr = int'(bufRdAddr);
        if (fcsReq) nFcs++;
        if (inGap) begin
          int e = (injected > 10) ? 10 : injected;
          if (gap > ((1 << e) - 1) * SLOT + 1) gapErr++;
          inGap = 0;
        end
        if (int'(bufRdAddr) == colAt && injected < colMax) begin
          colIn = 1'b1; injected++;
        end
      end
      if (jamActive) jamCyc++;
      if (prevJam && !jamActive) begin inGap = 1; gap = 0; end
      if (inGap && !jamActive && !txValid) gap++;
      prevJam = jamActive;
      nOk += int'(evTxOk); nLate += int'(evLate); nExc += int'(evExcess);
      nUn += int'(evUnderrun); nIrq += int'(irq);
    end
  endtask

  function automatic int events();
    return nOk + nLate + nExc + nUn;
  endfunction

  task automatic tReset();
    check(!txValid && !jamActive && !fcsReq, "R9 reset outputs idle", int'(txValid), 0);
    check(!evTxOk && !evLate && !evExcess && !evUnderrun && !irq, "R9 reset events low", int'(evTxOk), 0);
  endtask

  task automatic tStartPoints();
    colAt = -1; colMax = 0;
    bufLevel = 11'd4; issue(2'd0, 1'b0, 1'b0, 100); step(30);
    check(bytes == 0, "R1 no start below 5 bytes", bytes, 0);
    bufLevel = 11'd100; step(140);
    check(bytes == 100, "R1 sends after 5-byte point", bytes, 100);
    check(nOk == 1 && events() == 1, "R9 one TxOk", nOk, 1);
    bufLevel = 11'd79; issue(2'd3, 1'b0, 1'b0, 80); step(40);
    check(bytes == 0, "R1 full-frame start waits", bytes, 0);
    bufLevel = 11'd80; step(120);
    check(bytes == 80, "R1 full-frame sends", bytes, 80);
    bufLevel = 11'd380; issue(2'd1, 1'b0, 1'b0, 500); step(40);
    check(bytes == 0, "R1 381 point waits at 380", bytes, 0);
    bufLevel = 11'd381; step(420);
    check(bytes == 381, "R8 stops at buffer level", bytes, 381);
    check(nUn == 1 && events() == 1, "R8 underrun event", nUn, 1);
  endtask

  task automatic tPadFcs();
    colAt = -1; colMax = 0; bufLevel = 11'd10;
    issue(2'd3, 1'b0, 1'b0, 10); step(90);
    check(bytes == 60, "R2 padded to 60", bytes, 60);
    check(padErr == 0, "R2 data then zero pad", padErr, 0);
    check(lastAddr == 59, "R2 last at 59", lastAddr, 59);
    check(nFcs == 1, "R3 fcs requested", nFcs, 1);
    issue(2'd3, 1'b1, 1'b1, 10); step(40);
    check(bytes == 10 && lastAddr == 9, "R2 no pad when disabled", bytes, 10);
    check(nFcs == 0, "R3 fcs inhibited", nFcs, 0);
    check(nOk == 1, "R9 TxOk after short frame", nOk, 1);
  endtask

  task automatic tShort();
    colAt = -1; colMax = 0; bufLevel = 11'd10;
    issue(2'd0, 1'b1, 1'b0, 2); step(30);
    check(bytes == 0 && events() == 0, "R4 length 2 not sent", bytes, 0);
    issue(2'd0, 1'b1, 1'b0, 3); step(30);
    check(bytes == 3 && nOk == 1, "R4 length 3 sent after", bytes, 3);
  endtask

  task automatic tCollisions();
    bufLevel = 11'd100;
    colAt = 10; colMax = 1; issue(2'd0, 1'b0, 1'b0, 100); step(300);
    check(jamCyc == 4, "R5 jam length", jamCyc, 4);
    check(attempts == 2 && nOk == 1, "R5 retry then TxOk", attempts, 2);
    check(gapErr == 0, "R10 backoff bound", gapErr, 0);
    colAt = 63; colMax = 1; issue(2'd0, 1'b0, 1'b0, 100); step(300);
    check(attempts == 2 && nOk == 1 && nLate == 0, "R5 byte 63 in window", attempts, 2);
    colAt = 64; colMax = 1; issue(2'd0, 1'b0, 1'b0, 100); step(300);
    check(jamCyc == 4 && attempts == 1, "R6 late no retry", attempts, 1);
    check(nLate == 1 && events() == 1, "R6 late event", nLate, 1);
    excessIrqEn = 1'b1;
    colAt = 3; colMax = 16; issue(2'd0, 1'b0, 1'b0, 100); step(40000);
    check(attempts == 16 && nOk == 0, "R7 sixteen attempts", attempts, 16);
    check(nExc == 1 && nIrq == 1 && events() == 1, "R7 excess event and irq", nExc, 1);
    check(jamCyc == 64, "R5 jam per collision", jamCyc, 64);
    check(gapErr == 0, "R10 backoff bound capped", gapErr, 0);
    excessIrqEn = 1'b0;
    colAt = 3; colMax = 16; issue(2'd0, 1'b0, 1'b0, 100); step(40000);
    check(nExc == 1 && nIrq == 0, "R7 irq masked", nIrq, 0);
    colAt = 3; colMax = 15; issue(2'd0, 1'b0, 1'b0, 100); step(40000);
    check(attempts == 16 && nOk == 1 && nExc == 0, "R7 fifteen then success", nOk, 1);
  endtask

  initial begin
    colAt = -1; colMax = 0; clearStats();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tStartPoints();
    tPadFcs();
    tShort();
    tCollisions();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule